// File: doc/BRIEF.md
# Recirculating Request Ring with Replay

This block keeps outstanding memory requests moving around a ring of pipeline slots instead of parking them in a queue. A new read or write request arrives on a valid/ready request port. Before it is injected, its burst is checked. It receives an age stamp from a wrapping counter. It then enters the ring in the slot that has just come free. Every slot advances one position per clock. The slot at the last position is the decision point, where a router sends the request to one of three places: the read buffer, the write buffer, or the replay path. A request on the replay path goes back into the ring for another pass.

A request is replayed for any of three reasons. The first is that an older request with the same ID is still in the ring, which keeps per-ID order. The second is that the tag lookup input reports its cache line as busy filling. The third applies to a write: an older read to the same 64-byte line is still circulating. Recirculation always wins over injection, so the request port is ready only while the decision slot is empty or its occupant is leaving. The tag array, the data buffers and the external memory port lie outside this block. The lookup answer arrives as a single busy input against the address presented at the decision point.

Top module: `rrl_loop`

## Requirements
- R1: After reset the ring is empty, `req_ready` is 1, and `rd_valid`, `wr_valid`, `rp_valid` and `req_err` are 0.
- R2: A request accepted at clock edge E that meets no hazard leaves at edge E+SLOTS. It is reported for one cycle on `rd_valid` (read, `req_write`=0) or `wr_valid` (write, `req_write`=1), with its own ID on `out_id` and its own address on `out_addr`.
- R3: A request is rejected when any of these holds: `req_burst` is not 2'b01 (incrementing), `req_bytes` is 0 or above 64, `req_addr[2:0]` is not zero, or the burst crosses a 64-byte line boundary. A rejected request is consumed, pulses `req_err` in the cycle after acceptance, and never enters the ring or leaves it.
- R4: A request at the decision point is replayed while an older request with the same ID is in the ring. Requests with one ID therefore leave in the order they were accepted.
- R5: A request at the decision point is replayed while `lk_busy` is 1 in that cycle. `lk_valid` and `lk_addr` present the decision-point request.
- R6: A write at the decision point is replayed while an older read to the same 64-byte line (`addr[ADDR_W-1:6]`) is in the ring.
- R7: Each decision routes to at most one of read, write and replay. Every accepted good request leaves the ring exactly once.
- R8: A replayed request keeps its slot and blocks injection. `req_ready` is 0 while the decision slot holds a request that stays, so the ring never holds more than SLOTS requests.
- R9: Age comparison is wrap-safe modular arithmetic on a TS_W-bit stamp that increments on each injection. Ordering stays correct after the stamp wraps, provided that fewer than 2^(TS_W-1) injections separate live requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Request consumed this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Transaction ID |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | 7 | Burst length in bytes |
| req_burst | input | 2 | Burst kind, 2'b01 = incrementing |
| req_err | output | 1 | Rejected request pulse |
| lk_valid | output | 1 | Decision slot occupied |
| lk_addr | output | ADDR_W | Address at the decision slot |
| lk_busy | input | 1 | Line at `lk_addr` is being filled |
| rd_valid | output | 1 | Request leaves to the read buffer |
| wr_valid | output | 1 | Request leaves to the write buffer |
| rp_valid | output | 1 | Request replayed this pass |
| out_id | output | ID_W | ID of the routed request |
| out_addr | output | ADDR_W | Address of the routed request |

## Verification
The assertions assume three things about the inputs. `lk_busy` is a same-cycle function of `lk_addr`. The request fields stay stable while `req_valid` is high and `req_ready` is low. No live request is older than half the stamp range. The stimulus meets these assumptions: it derives the busy line combinationally from `lk_addr`, holds each request until it is taken, keeps fewer than 64 requests between any two live ones, and always clears busy lines so that every request eventually leaves.

// File: rtl/rrl_pkg.sv
package rrl_pkg;
  localparam int ID_W      = 4;
  localparam int ADDR_W    = 32;
  localparam int TS_W      = 8;
  localparam int LINE_BITS = 6;
  localparam int BEAT_BITS = 3;
  localparam int BYTES_W   = LINE_BITS + 1;
  localparam int LINE_BYTES = 1 << LINE_BITS;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef struct packed {
    logic              v;
    logic              wr;
    logic [ID_W-1:0]   id;
    logic [TS_W-1:0]   ts;
    logic [ADDR_W-1:0] addr;
  } slot_t;

  // a is older than b when (a - b) is negative modulo 2^TS_W
  function automatic logic ts_older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return d[TS_W-1];
  endfunction

  function automatic logic [ADDR_W-LINE_BITS-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_BITS];
  endfunction

  function automatic logic burst_bad(input logic [ADDR_W-1:0] a, input logic [BYTES_W-1:0] n,
                                     input logic [1:0] bt);
    logic [BYTES_W:0] last;
    last = {2'b00, a[LINE_BITS-1:0]} + {1'b0, n};
    return (bt != BURST_INCR) || (n == '0) || (n > BYTES_W'(LINE_BYTES)) ||
           (a[BEAT_BITS-1:0] != '0) || (last > (BYTES_W+1)'(LINE_BYTES));
  endfunction
endpackage

// File: rtl/rrl_hazard.sv
module rrl_hazard
  import rrl_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  slot_t [SLOTS-1:0] ring_i,
  output logic              id_block_o,
  output logic              line_block_o
);
  localparam int OTHERS = SLOTS - 1;

  slot_t             tail;
  logic [OTHERS-1:0] same_id_older;
  logic [OTHERS-1:0] read_same_line;

  assign tail = ring_i[SLOTS-1];

  for (genvar j = 0; j < OTHERS; j++) begin : g_cmp
    logic older;
    assign older = ring_i[j].v && ts_older(ring_i[j].ts, tail.ts);
    assign same_id_older[j]  = older && (ring_i[j].id == tail.id);
    assign read_same_line[j] = older && tail.wr && !ring_i[j].wr &&
                               (line_of(ring_i[j].addr) == line_of(tail.addr));
  end

  assign id_block_o   = |same_id_older;
  assign line_block_o = |read_same_line;
endmodule

// File: rtl/rrl_router.sv
module rrl_router
  import rrl_pkg::*;
(
  input  slot_t tail_i,
  input  logic  id_block_i,
  input  logic  line_block_i,
  input  logic  lk_busy_i,
  output logic  to_rd_o,
  output logic  to_wr_o,
  output logic  to_rp_o
);
  logic hold;
  assign hold    = id_block_i || line_block_i || lk_busy_i;
  assign to_rp_o = tail_i.v && hold;
  assign to_rd_o = tail_i.v && !hold && !tail_i.wr;
  assign to_wr_o = tail_i.v && !hold && tail_i.wr;
endmodule

// File: rtl/rrl_arbiter.sv
module rrl_arbiter
  import rrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_free_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ID_W-1:0]    req_id_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [BYTES_W-1:0] req_bytes_i,
  input  logic [1:0]         req_burst_i,
  output logic               ready_o,
  output logic               take_o,
  output logic               reject_o,
  output slot_t              new_slot_o
);
  logic [TS_W-1:0] stamp_q;
  logic            bad;

  assign bad      = burst_bad(req_addr_i, req_bytes_i, req_burst_i);
  assign ready_o  = slot_free_i;
  assign take_o   = req_valid_i && slot_free_i && !bad;
  assign reject_o = req_valid_i && slot_free_i && bad;

  always_comb begin
    new_slot_o      = '0;
    new_slot_o.v    = 1'b1;
    new_slot_o.wr   = req_write_i;
    new_slot_o.id   = req_id_i;
    new_slot_o.ts   = stamp_q;
    new_slot_o.addr = req_addr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      stamp_q <= '0;
    else if (take_o) stamp_q <= stamp_q + 1'b1;
  end
endmodule

// File: rtl/rrl_loop.sv
module rrl_loop
  import rrl_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ID_W-1:0]    req_id,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic [1:0]         req_burst,
  output logic               req_err,
  output logic               lk_valid,
  output logic [ADDR_W-1:0]  lk_addr,
  input  logic               lk_busy,
  output logic               rd_valid,
  output logic               wr_valid,
  output logic               rp_valid,
  output logic [ID_W-1:0]    out_id,
  output logic [ADDR_W-1:0]  out_addr
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  slot_t [SLOTS-1:0] ring_q;
  slot_t             tail;
  slot_t             new_slot;
  logic              id_block, line_block;
  logic              to_rd, to_wr, to_rp;
  logic              leaves, take, reject;
  logic [CNT_W-1:0]  occ_q;

  assign tail     = ring_q[SLOTS-1];
  assign leaves   = to_rd || to_wr;
  assign lk_valid = tail.v;
  assign lk_addr  = tail.addr;

  rrl_hazard #(.SLOTS(SLOTS)) u_hazard (
    .ring_i(ring_q), .id_block_o(id_block), .line_block_o(line_block)
  );

  rrl_router u_router (
    .tail_i(tail), .id_block_i(id_block), .line_block_i(line_block),
    .lk_busy_i(lk_busy), .to_rd_o(to_rd), .to_wr_o(to_wr), .to_rp_o(to_rp)
  );

  rrl_arbiter u_arbiter (
    .clk(clk), .rst_n(rst_n), .slot_free_i(!tail.v || leaves),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_id_i(req_id),
    .req_addr_i(req_addr), .req_bytes_i(req_bytes), .req_burst_i(req_burst),
    .ready_o(req_ready), .take_o(take), .reject_o(reject), .new_slot_o(new_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_q <= '0;
    end else begin
      for (int i = 1; i < SLOTS; i++) ring_q[i] <= ring_q[i-1];
      if (take)       ring_q[0] <= new_slot;
      else if (to_rp) ring_q[0] <= tail;
      else            ring_q[0] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      wr_valid <= 1'b0;
      rp_valid <= 1'b0;
      req_err  <= 1'b0;
      out_id   <= '0;
      out_addr <= '0;
      occ_q    <= '0;
    end else begin
      rd_valid <= to_rd;
      wr_valid <= to_wr;
      rp_valid <= to_rp;
      req_err  <= reject;
      out_id   <= tail.id;
      out_addr <= tail.addr;
      occ_q    <= occ_q + CNT_W'(take) - CNT_W'(leaves);
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wr_valid, rp_valid})); // R7
  AST_BUSY_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (tail.v && lk_busy) |=> (rp_valid && !rd_valid && !wr_valid)); // R5
  AST_ID_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (tail.v && id_block) |=> rp_valid); // R4
  AST_LINE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (tail.v && line_block) |=> rp_valid); // R6
  AST_REJECT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && reject) |=> (req_err && !ring_q[0].v)); // R3
  AST_REPLAY_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid |-> (ring_q[0].v && ring_q[0].addr == out_addr)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(SLOTS)); // R8
endmodule

// File: tb/rrl_loop_bench.sv
module rrl_loop_bench;
  localparam int SL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_id = '0;
  logic [31:0] req_addr = '0;
  logic [6:0]  req_bytes = '0;
  logic [1:0]  req_burst = '0;
  logic        req_ready, req_err, lk_valid, lk_busy;
  logic [31:0] lk_addr, out_addr;
  logic        rd_valid, wr_valid, rp_valid;
  logic [3:0]  out_id;

  bit          busy_on = 1'b0;
  logic [25:0] busy_line = '0;

  int errs = 0, checks = 0;
  int acc_n = 0, ex_n = 0, rp_seen = 0;
  logic [31:0] acc_addr [512];
  bit          acc_wr   [512];
  int          acc_id   [512];
  int          exit_cnt [512];
  int          ex_log   [512];
  int          last_k   [16];

  always #4 clk = ~clk;

  assign lk_busy = busy_on && lk_valid && ((lk_addr / 64) == {6'd0, busy_line});

  rrl_loop #(.SLOTS(SL)) u_rrl_loop (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_id(req_id), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_burst(req_burst), .req_err(req_err),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_busy(lk_busy),
    .rd_valid(rd_valid), .wr_valid(wr_valid), .rp_valid(rp_valid),
    .out_id(out_id), .out_addr(out_addr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit bench_bad(input logic [31:0] a, input int nb, input logic [1:0] bt);
    return !(bt == 2'b01 && nb >= 1 && nb <= 64 && (a % 8) == 0 && (a % 64) + nb <= 64);
  endfunction

  // exit monitor: exactly once, right kind, per-ID order (R2, R4, R7)
  always @(negedge clk) begin
    if (rst_n && rp_valid) rp_seen++;
    if (rst_n && (rd_valid || wr_valid)) begin
      int k = -1;
      for (int i = 0; i < acc_n; i++) if (acc_addr[i] == out_addr) k = i;
      check(k >= 0, "R7 unknown exit addr", out_addr, 0);
      if (k >= 0) begin
        exit_cnt[k]++;
        check(exit_cnt[k] == 1, "R7 exit count", exit_cnt[k], 1);
        check(wr_valid == acc_wr[k], "R2 route", wr_valid, acc_wr[k]);
        check(out_id == acc_id[k][3:0], "R2 id", out_id, acc_id[k]);
        check(k > last_k[acc_id[k]], "R4 id order", k, last_k[acc_id[k]]);
        last_k[acc_id[k]] = k;
        ex_log[ex_n] = k;
        ex_n++;
      end
    end
  end

  task automatic send(input bit w, input int id, input logic [31:0] a, input int nb,
                      input logic [1:0] bt, output int k);
    bit bad;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_id = id[3:0]; req_addr = a;
    req_bytes = nb[6:0]; req_burst = bt;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    bad = bench_bad(a, nb, bt);
    k = -1;
    if (!bad) begin
      k = acc_n;
      acc_addr[k] = a; acc_wr[k] = w; acc_id[k] = id; exit_cnt[k] = 0;
      acc_n++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(req_err == bad, "R3 err pulse", req_err, bad);
  endtask

  task automatic drain();
    int n = 0;
    forever begin
      int done = 0;
      for (int i = 0; i < acc_n; i++) if (exit_cnt[i] > 0) done++;
      if (done == acc_n || n > 3000) break;
      @(negedge clk); n++;
    end
    repeat (SL + 2) @(negedge clk);
  endtask

  function automatic int pos_of(input int k);
    for (int i = 0; i < ex_n; i++) if (ex_log[i] == k) return i;
    return -1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int k, ka, kb, kc;
    for (int i = 0; i < 16; i++) last_k[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check({rd_valid, wr_valid, rp_valid, req_err} == 4'b0, "R1 outputs",
          {rd_valid, wr_valid, rp_valid, req_err}, 0);
    check(lk_valid == 1'b0, "R1 empty", lk_valid, 0);

    // R2 read latency: visible at the SL-th negedge after the one following acceptance
    send(1'b0, 1, 32'h100, 8, 2'b01, k);
    repeat (SL - 1) @(negedge clk);
    check(!rd_valid, "R2 early read", rd_valid, 0);
    @(negedge clk);
    check(rd_valid && out_addr == 32'h100, "R2 read exit", rd_valid, 1);
    // R2 write
    send(1'b1, 2, 32'h140, 64, 2'b01, k);
    repeat (SL - 1) @(negedge clk);
    check(!wr_valid, "R2 early write", wr_valid, 0);
    @(negedge clk);
    check(wr_valid && out_addr == 32'h140 && !rd_valid, "R2 write exit", wr_valid, 1);
    drain();

    // R3 rejection sweep
    send(1'b0, 0, 32'h200, 8, 2'b00, k);
    send(1'b0, 0, 32'h208, 8, 2'b10, k);
    send(1'b0, 0, 32'h210, 8, 2'b11, k);
    send(1'b0, 0, 32'h218, 0, 2'b01, k);
    send(1'b0, 0, 32'h240, 65, 2'b01, k);
    send(1'b0, 0, 32'h284, 8, 2'b01, k);
    send(1'b1, 0, 32'h2B8, 16, 2'b01, k);
    send(1'b0, 0, 32'h2C0, 64, 2'b01, k);
    send(1'b1, 0, 32'h338, 8, 2'b01, k);
    drain();
    check(acc_n == 4, "R3 accepted count", acc_n, 4);

    // R5 busy line replays until cleared
    busy_on = 1'b1; busy_line = 26'h10;
    rp_seen = 0;
    send(1'b0, 5, 32'h400, 8, 2'b01, ka);
    repeat (4 * SL) @(negedge clk);
    check(exit_cnt[ka] == 0, "R5 held while busy", exit_cnt[ka], 0);
    check(rp_seen > 1, "R5 replayed", rp_seen, 2);
    busy_on = 1'b0;
    drain();
    check(exit_cnt[ka] == 1, "R5 exit after clear", exit_cnt[ka], 1);

    // R4 same ID: younger blocked behind busy older
    busy_on = 1'b1; busy_line = 26'h20;
    send(1'b0, 3, 32'h800, 8, 2'b01, ka);
    send(1'b0, 3, 32'h900, 8, 2'b01, kb);
    repeat (4 * SL) @(negedge clk);
    check(exit_cnt[kb] == 0, "R4 younger held", exit_cnt[kb], 0);
    busy_on = 1'b0;
    drain();
    check(pos_of(ka) < pos_of(kb), "R4 order", pos_of(kb), pos_of(ka));

    // R6 write behind older read to same line
    busy_on = 1'b1; busy_line = 26'h30;
    send(1'b0, 1, 32'hC00, 8, 2'b01, ka);
    send(1'b0, 1, 32'hD00, 8, 2'b01, kb);
    send(1'b1, 2, 32'hD08, 8, 2'b01, kc);
    repeat (4 * SL) @(negedge clk);
    check(exit_cnt[kc] == 0, "R6 write held", exit_cnt[kc], 0);
    busy_on = 1'b0;
    drain();
    check(pos_of(kb) < pos_of(kc), "R6 write after read", pos_of(kc), pos_of(kb));

    // R8 full ring blocks injection
    busy_on = 1'b1; busy_line = 26'h40;
    for (int i = 0; i < SL; i++) send(1'b0, i, 32'h1000 + 32'(i * 8), 8, 2'b01, k);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_id = 4'd9; req_addr = 32'h1400;
    req_bytes = 7'd8; req_burst = 2'b01;
    for (int i = 0; i < 2 * SL; i++) begin
      #1;
      check(!req_ready, "R8 ready low when full", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    busy_on = 1'b0;
    send(1'b0, 9, 32'h1400, 8, 2'b01, k);
    drain();

    // R7 R9 sweep: mixed traffic, stamp wraps, busy lines toggle
    for (int i = 0; i < 300; i++) begin
      int r = $urandom % 8;
      if (r == 0) begin busy_on = !busy_on; busy_line = 26'((32'h10000 + 32'(i * 8)) / 64); end
      if (i % 40 == 39) begin busy_on = 1'b0; drain(); end
      send(($urandom % 2) == 1, int'($urandom % 4), 32'h10000 + 32'(i * 8), 8,
           (i % 23 == 0) ? 2'b10 : 2'b01, k);
      if (r == 1) @(negedge clk);
    end
    busy_on = 1'b0;
    drain();
    for (int i = 0; i < acc_n; i++)
      check(exit_cnt[i] == 1, "R7 exactly once", exit_cnt[i], 1);
    check(acc_n > 280, "R9 sweep size", acc_n, 281);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule